// File: doc/BRIEF.md
# Bank and Common Region Address Translator

This block sits between a CPU with a 16-bit logical address bus and a larger physical memory. The top four logical address bits name one of sixteen 4 KB pages. A bounds register splits those pages into three regions: a low common area that passes through unmapped, a banked middle area, and an upper common area. A page in one of the two mapped regions has its page number added to an 8-bit base register. The 8-bit sum becomes the top of a 20-bit physical address.

Software programs the block through a small register port. A write strobe with a 2-bit select loads one of three 8-bit registers, and the same select reads a register back combinationally. Translation is purely combinational from the logical address and the registers as currently held. A new mapping therefore applies to the first address presented after the write edge.

Top module: `bankmap_mmu`

## Requirements
- R1: Physical address bits [11:0] always equal logical address bits [11:0].
- R2: With page = logical[15:12], bankStart = bounds[3:0] and upperStart = bounds[7:4], the region is chosen in this order: upper common if page >= upperStart, else banked if page >= bankStart, else low common. A bankStart of 0 leaves the low area empty, and upperStart <= bankStart leaves the banked area empty.
- R3: In the low common area, the physical address equals the logical address zero-extended to 20 bits.
- R4: In the banked area, physical[19:12] = (bankBase + page) mod 256; the carry is dropped.
- R5: In the upper common area, physical[19:12] = (upperBase + page) mod 256; the carry is dropped.
- R6: After reset, bounds = 8'hF0 and both bases = 0, so every logical address maps to itself.
- R7: On a rising clock edge with wrEn high, wrData loads the register named by regSel: 0 = bounds, 1 = bankBase, 2 = upperBase. The next address presented is translated with the new value.
- R8: rdData shows, without a clock, the register named by regSel. Select 3 reads as 0, and a write to select 3 changes no register.
- R9: A register keeps its value on every edge without a write to its select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for write and read |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read-back of the selected register |
| logAddr | input | 16 | Logical CPU address |
| physAddr | output | 20 | Translated physical address |

## Verification
The assertions assume that wrEn, regSel, wrData and logAddr carry known values at each rising edge once reset is released. They also assume that wrEn stays low while reset is asserted, because the write-landing checks look one cycle back across the reset boundary. The bench changes every input only at the falling edge, holds wrEn low throughout reset, and leaves no input undriven. It sweeps all sixteen pages under each bounds setting, including both empty-region arrangements, and it includes writes and reads on the reserved select.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  typedef enum logic [1:0] {
    SEL_BOUNDS = 2'd0,
    SEL_BANK   = 2'd1,
    SEL_UPPER  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    AREA_LOW   = 2'd0,
    AREA_BANK  = 2'd1,
    AREA_UPPER = 2'd2
  } area_e;

  typedef struct packed {
    logic wrBounds;
    logic wrBank;
    logic wrUpper;
    logic rdBounds;
    logic rdBank;
    logic rdUpper;
  } regStrobe_t;

endpackage

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import bankmap_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] regSel,
  output regStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (regSel_e'(regSel))
      SEL_BOUNDS: begin strobe.rdBounds = 1'b1; strobe.wrBounds = wrEn; end
      SEL_BANK:   begin strobe.rdBank   = 1'b1; strobe.wrBank   = wrEn; end
      SEL_UPPER:  begin strobe.rdUpper  = 1'b1; strobe.wrUpper  = wrEn; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/bankmap_dp.sv
module bankmap_dp
  import bankmap_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_BOUNDS = 8'hF0,
  localparam int PAGE_W = LOG_W - OFF_W,
  localparam int PHYS_W = DATA_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LOG_W-1:0]  logAddr,
  output logic [PHYS_W-1:0] physAddr,
  output logic [DATA_W-1:0] boundsQ,
  output logic [DATA_W-1:0] bankBaseQ,
  output logic [DATA_W-1:0] upperBaseQ
);

  logic [PAGE_W-1:0] page, bankStart, upperStart;
  logic [DATA_W-1:0] physHi;
  area_e             area;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boundsQ    <= RST_BOUNDS;
      bankBaseQ  <= '0;
      upperBaseQ <= '0;
    end else begin
      if (strobe.wrBounds) boundsQ    <= wrData;
      if (strobe.wrBank)   bankBaseQ  <= wrData;
      if (strobe.wrUpper)  upperBaseQ <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdBounds) rdData = boundsQ;
    if (strobe.rdBank)   rdData = bankBaseQ;
    if (strobe.rdUpper)  rdData = upperBaseQ;
  end

  assign page       = logAddr[LOG_W-1 -: PAGE_W];
  assign bankStart  = boundsQ[PAGE_W-1:0];
  assign upperStart = boundsQ[2*PAGE_W-1 -: PAGE_W];

  always_comb begin
    if (page >= upperStart)     area = AREA_UPPER;
    else if (page >= bankStart) area = AREA_BANK;
    else                        area = AREA_LOW;
  end

  always_comb begin
    unique case (area)
      AREA_BANK:  physHi = DATA_W'(bankBaseQ  + DATA_W'(page));
      AREA_UPPER: physHi = DATA_W'(upperBaseQ + DATA_W'(page));
      default:    physHi = DATA_W'(page);
    endcase
  end

  assign physAddr = {physHi, logAddr[OFF_W-1:0]};

endmodule

// File: rtl/bankmap_mmu.sv
module bankmap_mmu
  import bankmap_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_BOUNDS = 8'hF0,
  localparam int PHYS_W = DATA_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LOG_W-1:0]  logAddr,
  output logic [PHYS_W-1:0] physAddr
);

  regStrobe_t        strobe;
  logic [DATA_W-1:0] boundsQ, bankBaseQ, upperBaseQ;

  bankmap_ctrl u_ctrl (
    .wrEn   (wrEn),
    .regSel (regSel),
    .strobe (strobe)
  );

  bankmap_dp #(
    .LOG_W(LOG_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .RST_BOUNDS(RST_BOUNDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .rdData     (rdData),
    .logAddr    (logAddr),
    .physAddr   (physAddr),
    .boundsQ    (boundsQ),
    .bankBaseQ  (bankBaseQ),
    .upperBaseQ (upperBaseQ)
  );

endmodule

// File: rtl/bankmap_chk.sv
module bankmap_chk #(
  parameter int LOG_W  = 16,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 8,
  localparam int PAGE_W = LOG_W - OFF_W,
  localparam int PHYS_W = DATA_W + OFF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        regSel,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [LOG_W-1:0]  logAddr,
  input logic [PHYS_W-1:0] physAddr,
  input logic [DATA_W-1:0] boundsQ,
  input logic [DATA_W-1:0] bankBaseQ,
  input logic [DATA_W-1:0] upperBaseQ
);

  logic [PAGE_W-1:0] pg, bLo, bHi;
  assign pg  = logAddr[LOG_W-1 -: PAGE_W];
  assign bLo = boundsQ[PAGE_W-1:0];
  assign bHi = boundsQ[2*PAGE_W-1 -: PAGE_W];

  a_r1_offset_passthru: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[OFF_W-1:0] == logAddr[OFF_W-1:0]);

  a_r3_low_identity: assert property (@(posedge clk) disable iff (!rstN)
    (pg < bLo && pg < bHi) |-> physAddr == PHYS_W'(logAddr));

  a_r4_bank_add: assert property (@(posedge clk) disable iff (!rstN)
    (pg >= bLo && pg < bHi) |->
      physAddr[PHYS_W-1:OFF_W] == DATA_W'(bankBaseQ + DATA_W'(pg)));

  a_r5_upper_add: assert property (@(posedge clk) disable iff (!rstN)
    (pg >= bHi) |->
      physAddr[PHYS_W-1:OFF_W] == DATA_W'(upperBaseQ + DATA_W'(pg)));

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && $past(regSel) == 2'd1) |-> bankBaseQ == $past(wrData));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd3) |-> rdData == '0);

  a_r9_bounds_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !($past(wrEn) && $past(regSel) == 2'd0)) |-> $stable(boundsQ));

  a_r9_upper_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !($past(wrEn) && $past(regSel) == 2'd2)) |-> $stable(upperBaseQ));

endmodule

bind bankmap_mmu bankmap_chk #(.LOG_W(LOG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .regSel     (regSel),
  .wrData     (wrData),
  .rdData     (rdData),
  .logAddr    (logAddr),
  .physAddr   (physAddr),
  .boundsQ    (boundsQ),
  .bankBaseQ  (bankBaseQ),
  .upperBaseQ (upperBaseQ)
);

// File: tb/tb_bankmap_mmu.sv
module tb_bankmap_mmu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic [15:0] logAddr = 16'd0;
  logic [19:0] physAddr;

  int nRun = 0;
  int nFail = 0;
  int mBounds = 'hF0;
  int mBank = 0;
  int mUpper = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bankmap_mmu dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .logAddr(logAddr), .physAddr(physAddr)
  );

  function automatic int expPhys(int a);
    int pg, lo, hi, hiBits;
    pg = (a >> 12) & 15;
    lo = mBounds & 15;
    hi = (mBounds >> 4) & 15;
    if (pg >= hi)      hiBits = (mUpper + pg) & 255;
    else if (pg >= lo) hiBits = (mBank + pg) & 255;
    else               hiBits = pg;
    return (hiBits << 12) | (a & 'hFFF);
  endfunction

  function automatic string areaTag(int a);
    int pg;
    pg = (a >> 12) & 15;
    if (pg >= ((mBounds >> 4) & 15)) return "R2/R5";
    if (pg >= (mBounds & 15))        return "R2/R4";
    return "R2/R3";
  endfunction

  function automatic int expRead(int s);
    case (s)
      0: return mBounds;
      1: return mBank;
      2: return mUpper;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, compare just after, apply the write at the rising edge.
  task automatic step(bit wr, int sel, int data, int addr, string rdTag);
    @(negedge clk);
    wrEn = wr; regSel = 2'(sel); wrData = 8'(data); logAddr = 16'(addr);
    #1;
    check({areaTag(addr), "/R1 phys"}, int'(physAddr), expPhys(addr));
    check(rdTag, int'(rdData), expRead(sel));
    @(posedge clk);
    if (rstN && wr) begin
      case (sel)
        0: mBounds = data;
        1: mBank = data;
        2: mUpper = data;
        default: ;
      endcase
    end
  endtask

  task automatic sweep(int sel);
    for (int p = 0; p < 16; p++)
      step(0, sel, 0, (p << 12) | ((p * 'h13D) & 'hFFF), "R8 read");
  endtask

  initial begin
    // R6: reset values and identity map while reset is held
    for (int s = 0; s < 3; s++) begin
      step(0, s, 0, 'h1234 + s * 'h4321, "R6 reset read");
    end
    rstN = 1'b1;
    sweep(0);
    // R7: program banked pages 4..7 and upper pages 8..15
    step(1, 0, 'h84, 'h5ABC, "R7 pre-write");
    step(1, 1, 'h10, 'h6001, "R7 pre-write");
    step(1, 2, 'h20, 'h9FFF, "R7 pre-write");
    sweep(1);
    // R4/R5: carry dropped
    step(1, 1, 'hFF, 'h4000, "R7 pre-write");
    step(1, 2, 'hFE, 'hF123, "R7 pre-write");
    sweep(2);
    // R2: empty low area
    step(1, 0, 'hA0, 'h0000, "R7 pre-write");
    sweep(0);
    // R2: bounds inverted, banked area empty
    step(1, 0, 'h38, 'h2222, "R7 pre-write");
    sweep(1);
    // R2: upper start zero, everything upper
    step(1, 0, 'h05, 'h3333, "R7 pre-write");
    sweep(2);
    // R8: reserved select writes nothing
    step(1, 3, 'hAA, 'h7777, "R8 reserved");
    step(1, 3, 'h55, 'h8888, "R8 reserved");
    for (int s = 0; s < 4; s++) step(0, s, 0, 'hC0DE, "R8 after reserved write");
    // R9: idle cycles keep registers
    for (int i = 0; i < 4; i++) step(0, i & 3, 0, i * 'h3F11, "R9 hold");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule